// File: doc/BRIEF.md
# Route-Partitioned LRU Victim Selector

This block chooses which way of a set-associative ECC cache is replaced on a miss. Each way has a 16-bit allocation word that can reserve it for a single requester route ID. When a request arrives, the block looks at the route ID and at the per-way tag-match, valid and dirty status. It reports a hit and the index of the hit way. On a miss it names a victim way and says whether that way holds dirty data that must be written back.

Victims are restricted by route. A requester whose route ID is named in at least one enabled allocation word may only fill its own reserved ways. Every other requester fills from the pool of ways that no enabled word claims. If software enables every allocation word, the highest-numbered way is still treated as shared. The stored word for that way is left untouched, and it reads back exactly as it was written.

Among the permitted ways, an empty way is taken first. When no permitted way is empty, the least recently used way is taken. Recency is held as a distinct age per way, and both hits and fills update it.

Top module: `rid_lru_alloc`

## Requirements
- R1: An allocation word is 16 bits. Bit 15 is the enable flag and bits [7:0] hold the route ID. A write through `cfg_we`/`cfg_idx`/`cfg_wdata` takes effect at the clock edge. `cfg_rdata` shows the stored word of way `cfg_idx` combinationally, and every word is 0 after reset.
- R2: A request hits when some way has both `way_hit` and `way_valid` set, regardless of allocation. The next cycle shows `rsp_hit`=1, `rsp_way` = the lowest such way, and `vic_valid`=0.
- R3: On a miss by a requester whose route ID equals bits [7:0] of one or more enabled words, the victim is one of those ways.
- R4: On a miss by a requester that matches no enabled word, the victim is a way whose word has bit 15 clear.
- R5: When all words have bit 15 set, way W-1 is treated as unallocated: it is removed from its route's reserved set and becomes the only shared way. Its stored word still reads back unchanged.
- R6: If a permitted way has `way_valid`=0, the victim is the lowest-indexed such way, and `vic_dirty` is 0.
- R7: If every permitted way is valid, the victim is the permitted way with the oldest age. After reset, way i has age i, so higher indices count as older.
- R8: Every request updates recency. The accessed way (the hit way or the victim) gets age 0, and each way whose age was below the accessed way's old age ages by one.
- R9: One cycle after each request, `rsp_valid` pulses for one cycle. On a miss, `vic_valid` pulses in the same cycle, `rsp_way` is the victim, and `vic_dirty` = `way_valid & way_dirty` of the victim as sampled with the request. No response appears without a request.
- R10: A requester with exactly one reserved way gets that way as the victim on every miss.
- R11: A request in the same cycle as a configuration write is decided with the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Allocation word write strobe |
| cfg_idx | input | 7 | Way index for write and readback |
| cfg_wdata | input | 16 | Allocation word to write |
| cfg_rdata | output | 16 | Stored allocation word of way `cfg_idx` |
| req_valid | input | 1 | Request strobe |
| req_rid | input | 8 | Route ID of the requester |
| way_valid | input | 128 | Per-way line valid |
| way_dirty | input | 128 | Per-way line dirty |
| way_hit | input | 128 | Per-way tag match |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | 7 | Hit way or victim way |
| vic_valid | output | 1 | Victim strobe on a miss |
| vic_dirty | output | 1 | Victim holds dirty valid data |

## Verification
A configuration write and a lookup can fall in the same cycle, and the lookup must use the table from before the write. The bench reprograms allocation words while requests keep flowing, including the step that enables the last word and so turns on the forced shared way. It also writes words with route IDs that are being requested in that same cycle. A behavioural model applies the write only after it has decided the request, and every response and readback is compared against that model on the following cycle.

// File: rtl/rpla_pkg.sv
package rpla_pkg;
  localparam int ENTRY_W = 16;
  localparam int EN_BIT  = 15;
  localparam int RID_W   = 8;

  typedef logic [ENTRY_W-1:0] entry_t;

  // New age of one way after an access whose target had age `pivot`.
  function automatic int unsigned age_step(input int unsigned cur,
                                           input int unsigned pivot,
                                           input bit          is_target);
    if (is_target)      return 0;
    else if (cur < pivot) return cur + 1;
    else                return cur;
  endfunction

  // Route match of one allocation word against a request route.
  function automatic bit word_claims(input entry_t w, input logic [RID_W-1:0] rid);
    return w[EN_BIT] && (w[RID_W-1:0] == rid);
  endfunction
endpackage

// File: rtl/rpla_pick.sv
module rpla_pick #(
  parameter int W  = 128,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (!found && vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rpla_table.sv
module rpla_table
  import rpla_pkg::*;
#(
  parameter int W  = 128,
  parameter int IW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  entry_t           wr_data,
  output entry_t           rd_data,
  input  logic [RID_W-1:0] rid,
  output logic [W-1:0]     cand_mask,
  output logic             forced_shared
);
  entry_t       words [W];
  logic [W-1:0] en_raw;
  logic [W-1:0] en_eff;
  logic [W-1:0] claim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < W; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_idx] <= wr_data;
    end
  end

  assign rd_data = words[wr_idx];

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_way
      assign en_raw[g] = words[g][EN_BIT];
      if (g == W - 1) begin : g_last
        assign en_eff[g] = en_raw[g] && !forced_shared;
      end else begin : g_rest
        assign en_eff[g] = en_raw[g];
      end
      assign claim[g] = en_eff[g] && word_claims(words[g], rid);
    end
  endgenerate

  assign forced_shared = &en_raw;
  assign cand_mask     = (|claim) ? claim : ~en_eff;
endmodule

// File: rtl/rpla_age.sv
module rpla_age
  import rpla_pkg::*;
#(
  parameter int W  = 128,
  parameter int IW = $clog2(W),
  parameter int AW = IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] upd_way,
  input  logic [W-1:0]  cand,
  output logic [IW-1:0] oldest_way
);
  logic [AW-1:0] age [W];
  logic [AW-1:0] pivot;
  logic [AW-1:0] best_age;
  logic          best_set;

  assign pivot = age[upd_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < W; i++) age[i] <= AW'(i);
    end else if (upd) begin
      for (int i = 0; i < W; i++)
        age[i] <= AW'(age_step(int'(age[i]), int'(pivot), IW'(i) == upd_way));
    end
  end

  always_comb begin
    oldest_way = '0;
    best_age   = '0;
    best_set   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (cand[i] && (!best_set || age[i] > best_age)) begin
        best_set   = 1'b1;
        best_age   = age[i];
        oldest_way = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rid_lru_alloc.sv
module rid_lru_alloc
  import rpla_pkg::*;
#(
  parameter int W  = 128,
  parameter int IW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic [7:0]       req_rid,
  input  logic [W-1:0]     way_valid,
  input  logic [W-1:0]     way_dirty,
  input  logic [W-1:0]     way_hit,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IW-1:0]    rsp_way,
  output logic             vic_valid,
  output logic             vic_dirty
);
  logic [W-1:0]  cand_mask;
  logic          forced_shared;
  logic          hit_any, inv_any;
  logic [IW-1:0] hit_idx, inv_idx, old_idx, victim, acc_way;
  logic          hit_event, fill_event;

  rpla_table #(.W(W), .IW(IW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .rid(req_rid),
    .cand_mask(cand_mask), .forced_shared(forced_shared)
  );

  rpla_pick #(.W(W), .IW(IW)) u_hit (
    .vec(way_hit & way_valid), .found(hit_any), .idx(hit_idx)
  );

  rpla_pick #(.W(W), .IW(IW)) u_inv (
    .vec(cand_mask & ~way_valid), .found(inv_any), .idx(inv_idx)
  );

  rpla_age #(.W(W), .IW(IW)) u_age (
    .clk(clk), .rst_n(rst_n), .upd(req_valid), .upd_way(acc_way),
    .cand(cand_mask), .oldest_way(old_idx)
  );

  assign victim     = inv_any ? inv_idx : old_idx;
  assign acc_way    = hit_any ? hit_idx : victim;
  assign hit_event  = req_valid && hit_any;
  assign fill_event = req_valid && !hit_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      vic_valid <= 1'b0;
      vic_dirty <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_event;
      vic_valid <= fill_event;
      vic_dirty <= fill_event && way_valid[victim] && way_dirty[victim];
      if (req_valid) rsp_way <= acc_way;
    end
  end
endmodule

// File: rtl/rid_lru_alloc_chk.sv
module rid_lru_alloc_chk #(
  parameter int W  = 128,
  parameter int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [IW-1:0] cfg_idx,
  input logic [15:0]   cfg_wdata,
  input logic [15:0]   cfg_rdata,
  input logic          req_valid,
  input logic [W-1:0]  way_valid,
  input logic [W-1:0]  cand_mask,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [IW-1:0] rsp_way,
  input logic          vic_valid,
  input logic          vic_dirty
);
  logic [W-1:0] cand_q;
  logic         inv_q;
  logic         armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      inv_q  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      cand_q <= cand_mask;
      inv_q  <= |(cand_mask & ~way_valid);
      armed  <= 1'b1;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !vic_valid); // R9
  AST_VIC_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> rsp_valid && !rsp_hit); // R2
  AST_VIC_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vic_valid) |-> cand_q[rsp_way]); // R3
  AST_POOL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> |cand_mask); // R5
  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vic_valid && inv_q) |-> !vic_dirty); // R6
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cfg_we) && cfg_idx == $past(cfg_idx)) |-> cfg_rdata == $past(cfg_wdata)); // R1
endmodule

bind rid_lru_alloc rid_lru_alloc_chk #(.W(W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
  .way_valid(way_valid), .cand_mask(cand_mask), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_way(rsp_way), .vic_valid(vic_valid),
  .vic_dirty(vic_dirty)
);

// File: tb/sim_rid_lru_alloc.sv
`timescale 1ns/1ps
module sim_rid_lru_alloc;
  localparam int W  = 128;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [7:0]    req_rid = '0;
  logic [W-1:0]  way_valid = '0, way_dirty = '0, way_hit = '0;
  logic          rsp_valid, rsp_hit, vic_valid, vic_dirty;
  logic [IW-1:0] rsp_way;

  always #4 clk = ~clk;

  rid_lru_alloc #(.W(W), .IW(IW)) u0 (.*);

  int total = 0, bad = 0;
  int m_tbl [W];
  int m_age [W];
  bit e_rv, e_hit, e_vv, e_vd;
  int e_way, e_rd;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(rsp_valid == e_rv, "R9 rsp_valid", rsp_valid, e_rv);
    chk(vic_valid == e_vv, "R9 vic_valid", vic_valid, e_vv);
    chk(cfg_rdata == e_rd[15:0], "R1 readback", cfg_rdata, e_rd);
    if (e_rv) begin
      chk(rsp_hit == e_hit, {e_tag, " rsp_hit"}, rsp_hit, e_hit);
      chk(rsp_way == e_way[IW-1:0], {e_tag, " rsp_way"}, rsp_way, e_way);
      if (!e_hit) chk(vic_dirty == e_vd, "R9 vic_dirty", vic_dirty, e_vd);
    end
  endtask

  // Drive one cycle of stimulus and predict the response from the model.
  task automatic cycle(input bit rq, input int rid, input bit we, input int idx, input int wd);
    int hw, vw, cnt, best;
    bit any_claim, forced, inv;
    bit cand [W];
    req_valid = rq; req_rid = rid[7:0];
    cfg_we = we; cfg_idx = idx[IW-1:0]; cfg_wdata = wd[15:0];
    e_rv = rq; e_hit = 0; e_vv = 0; e_vd = 0; e_tag = "";
    if (rq) begin
      forced = 1;
      for (int i = 0; i < W; i++) if (!m_tbl[i][15]) forced = 0;
      any_claim = 0;
      for (int i = 0; i < W; i++) begin
        cand[i] = m_tbl[i][15] && (m_tbl[i][7:0] == rid[7:0]) && !(forced && i == W-1);
        if (cand[i]) any_claim = 1;
      end
      if (!any_claim)
        for (int i = 0; i < W; i++) cand[i] = !m_tbl[i][15] || (forced && i == W-1);
      hw = -1;
      for (int i = W-1; i >= 0; i--) if (way_hit[i] && way_valid[i]) hw = i;
      if (hw >= 0) begin
        e_hit = 1; vw = hw; e_tag = "R2 R8";
      end else begin
        inv = 0; vw = -1; cnt = 0;
        for (int i = W-1; i >= 0; i--) if (cand[i] && !way_valid[i]) begin vw = i; inv = 1; end
        if (!inv) begin
          best = -1;
          for (int i = 0; i < W; i++) if (cand[i] && m_age[i] > best) begin best = m_age[i]; vw = i; end
        end
        for (int i = 0; i < W; i++) if (cand[i]) cnt++;
        e_vv = 1;
        e_vd = way_valid[vw] && way_dirty[vw];
        e_tag = any_claim ? (cnt == 1 ? "R3 R10" : "R3") : (forced ? "R4 R5" : "R4");
        e_tag = {e_tag, inv ? " R6" : " R7 R8"};
      end
      if (we) e_tag = {e_tag, " R11"};
      e_way = vw;
      best = m_age[vw];
      for (int i = 0; i < W; i++)
        if (i == vw) m_age[i] = 0; else if (m_age[i] < best) m_age[i]++;
    end
    if (we) m_tbl[idx] = wd & 16'hffff;
    e_rd = m_tbl[idx];
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic rnd_req(input int rid, input int vmode, input bit we, input int idx, input int wd);
    case (vmode)
      0: way_valid = '1;
      1: way_valid = rnd_vec();
      default: way_valid = rnd_vec() | rnd_vec() | rnd_vec();
    endcase
    way_dirty = rnd_vec();
    way_hit = '0;
    if ($urandom_range(0, 3) == 0) way_hit[$urandom_range(0, W-1)] = 1'b1;
    cycle(1, rid, we, idx, wd);
  endtask

  initial begin
    int rids [4] = '{8'h69, 8'h68, 8'h11, 8'h22};
    for (int i = 0; i < W; i++) begin m_tbl[i] = 0; m_age[i] = i; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // Reset state: no response, empty table (R1, R9)
    chk(rsp_valid == 0 && vic_valid == 0, "R9 reset outputs", rsp_valid, 0);
    chk(cfg_rdata == 16'h0, "R1 reset word", cfg_rdata, 0);

    // All valid, no reservations: oldest is W-1 after reset (R7), then W-2 (R8)
    way_valid = '1; way_dirty = '1; way_hit = '0;
    cycle(1, 8'h11, 0, 0, 0);
    cycle(1, 8'h11, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);

    // Program reservations while requests run (R3, R10, R11)
    for (int i = 0; i < 4; i++) rnd_req(8'h69, 2, 1, i, 16'h8069);
    rnd_req(8'h68, 0, 1, 10, 16'h8068);
    rnd_req(8'h68, 0, 0, 10, 0);
    rnd_req(8'h68, 0, 0, 10, 0);
    rnd_req(8'h68, 1, 1, 20, 16'h0068);  // enable clear: not a reservation
    for (int n = 0; n < 1500; n++)
      rnd_req(rids[$urandom_range(0, 2)], $urandom_range(0, 2),
              $urandom_range(0, 15) == 0, $urandom_range(0, W-1),
              $urandom_range(0, 1) ? 16'h8069 : 16'h0000);

    // Fill the whole table; last write enables the forced shared way (R5)
    for (int i = 0; i < W; i++) rnd_req(rids[i % 4], 0, 1, i, 16'h8022);
    for (int i = 0; i < W; i++) rnd_req(rids[i % 4], 0, 1, i, 16'h8022);
    cycle(0, 0, 0, W-1, 16'h8022);
    chk(cfg_rdata == 16'h8022, "R5 readback of forced way", cfg_rdata, 16'h8022);
    for (int n = 0; n < 400; n++)
      rnd_req(rids[2 + $urandom_range(0, 1)], $urandom_range(0, 2), 0, $urandom_range(0, W-1), 0);
    // Release one way and keep going
    for (int n = 0; n < 400; n++)
      rnd_req(rids[$urandom_range(0, 3)], $urandom_range(0, 2), n == 0, 5, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule